// File: doc/BRIEF.md
# Read/Write Mode Selection Arbiter

This block decides, cycle by cycle, whether the scheduler of a memory controller serves read traffic or write traffic. It holds a single mode bit and changes it only when the traffic type now being served has run dry while the other type is waiting, or when the other type has been declared critical. Keeping the mode sticky lets the controller build long runs of one direction and pay for bus turnarounds rarely.

The critical status of each traffic type comes from a separate starvation tracker. Bus ports can also raise urgency through per-port sideband inputs, one set for reads and one for writes. When a global forwarding enable is set, any urgent port drives the matching go-critical output. That output is also merged into the critical status the mode decision uses. When the enable is clear, the sideband inputs have no effect at all.

Top module: `rw_mode_arbiter`

## Requirements
- R1: While reset is asserted and after its release, the mode output `mode_wr` is 0 (read mode; 1 means write mode).
- R2: In read mode the mode becomes write at the next clock edge when either of two conditions holds: writes are effectively critical and reads are not, or writes are pending and no reads are pending.
- R3: In write mode the mode becomes read at the next clock edge when either of two conditions holds: reads are effectively critical and writes are not, or reads are pending and no writes are pending.
- R4: In every other case the mode holds. This covers the current type still having work while the other type is not critical, and both types being critical in the same cycle.
- R5: With `urgent_fwd_en` = 1, `rd_go_crit` equals the OR of all `rd_urgent` bits and `wr_go_crit` equals the OR of all `wr_urgent` bits, in the same cycle and with no register on the path.
- R6: With `urgent_fwd_en` = 0, both go-critical outputs are 0, and the urgent inputs have no effect on the mode.
- R7: Effective criticality for a type is its critical input ORed with its go-critical output.
- R8: The mode changes only at a rising clock edge. A change on the inputs between edges leaves `mode_wr` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_pending | input | 1 | At least one read is waiting |
| wr_pending | input | 1 | At least one write is waiting |
| rd_crit_in | input | 1 | Read store flagged critical by the starvation tracker |
| wr_crit_in | input | 1 | Write store flagged critical by the starvation tracker |
| rd_urgent | input | RD_PORTS | Per-port read urgency sideband |
| wr_urgent | input | WR_PORTS | Per-port write urgency sideband |
| urgent_fwd_en | input | 1 | Global enable for forwarding urgency |
| mode_wr | output | 1 | Current mode: 0 read, 1 write |
| rd_go_crit | output | 1 | Forwarded read go-critical |
| wr_go_crit | output | 1 | Forwarded write go-critical |

## Verification
The bench runs every combination of the two pending flags, the two critical inputs, the forwarding enable and two urgent bits per direction, starting once from read mode and once from write mode. Cases where only one type is pending show whether the run-dry rule is applied. Cases where one type is critical while the current type still has work show whether preemption is applied. Cases with both types critical show whether the tie keeps the mode. Urgent bits with the enable clear and with it set show whether the sideband is ignored or folded into the critical status, and a check before each edge shows that the mode moves only at the clock.

// File: rtl/marb_pkg.sv
package marb_pkg;

   typedef enum logic {
      MODE_RD = 1'b0,
      MODE_WR = 1'b1
   } marb_mode_e;

   function automatic marb_mode_e marb_next_mode(
      input marb_mode_e cur,
      input logic       rd_pend,
      input logic       wr_pend,
      input logic       rd_crit,
      input logic       wr_crit
   );
      marb_mode_e nxt;
      nxt = cur;
      if (cur == MODE_RD) begin
         if ((wr_crit && !rd_crit) || (wr_pend && !rd_pend))
            nxt = MODE_WR;
      end else begin
         if ((rd_crit && !wr_crit) || (rd_pend && !wr_pend))
            nxt = MODE_RD;
      end
      return nxt;
   endfunction

endpackage

// File: rtl/marb_urgent_fwd.sv
module marb_urgent_fwd #(
   parameter int PORTS = 4
) (
   input  logic             fwd_en,
   input  logic [PORTS-1:0] urgent,
   output logic             go_crit
);
   localparam int LAST = PORTS - 1;

   logic [LAST:0] gated;

   generate
      if (PORTS < 1) begin : g_bad_ports
         $error("marb_urgent_fwd: PORTS must be at least 1");
      end
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         assign gated[p] = urgent[p] & fwd_en;
      end
   endgenerate

   assign go_crit = |gated;
endmodule

// File: rtl/marb_mode_reg.sv
module marb_mode_reg
   import marb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_pend,
   input  logic       wr_pend,
   input  logic       rd_crit,
   input  logic       wr_crit,
   output marb_mode_e mode_q
);
   marb_mode_e mode_d;

   always_comb begin
      mode_d = marb_next_mode(mode_q, rd_pend, wr_pend, rd_crit, wr_crit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_RD;
      else        mode_q <= mode_d;
   end
endmodule

// File: rtl/rw_mode_arbiter.sv
module rw_mode_arbiter
   import marb_pkg::*;
#(
   parameter int RD_PORTS = 4,
   parameter int WR_PORTS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_pending,
   input  logic                wr_pending,
   input  logic                rd_crit_in,
   input  logic                wr_crit_in,
   input  logic [RD_PORTS-1:0] rd_urgent,
   input  logic [WR_PORTS-1:0] wr_urgent,
   input  logic                urgent_fwd_en,
   output logic                mode_wr,
   output logic                rd_go_crit,
   output logic                wr_go_crit
);
   generate
      if (RD_PORTS < 1 || WR_PORTS < 1) begin : g_bad_cfg
         $error("rw_mode_arbiter: each direction needs at least one port");
      end
   endgenerate

   logic       rd_fwd;
   logic       wr_fwd;
   logic       rd_crit_eff;
   logic       wr_crit_eff;
   marb_mode_e mode_q;

   marb_urgent_fwd #(.PORTS(RD_PORTS)) u_rd_fwd (
      .fwd_en  (urgent_fwd_en),
      .urgent  (rd_urgent),
      .go_crit (rd_fwd)
   );

   marb_urgent_fwd #(.PORTS(WR_PORTS)) u_wr_fwd (
      .fwd_en  (urgent_fwd_en),
      .urgent  (wr_urgent),
      .go_crit (wr_fwd)
   );

   assign rd_crit_eff = rd_crit_in | rd_fwd;
   assign wr_crit_eff = wr_crit_in | wr_fwd;

   marb_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_pend (rd_pending),
      .wr_pend (wr_pending),
      .rd_crit (rd_crit_eff),
      .wr_crit (wr_crit_eff),
      .mode_q  (mode_q)
   );

   assign mode_wr    = (mode_q == MODE_WR);
   assign rd_go_crit = rd_fwd;
   assign wr_go_crit = wr_fwd;
endmodule

// File: rtl/rw_mode_arbiter_chk.sv
module rw_mode_arbiter_chk #(
   parameter int RD_PORTS = 4,
   parameter int WR_PORTS = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rd_pending,
   input logic                wr_pending,
   input logic                rd_crit_in,
   input logic                wr_crit_in,
   input logic [RD_PORTS-1:0] rd_urgent,
   input logic [WR_PORTS-1:0] wr_urgent,
   input logic                urgent_fwd_en,
   input logic                mode_wr,
   input logic                rd_go_crit,
   input logic                wr_go_crit
);
   logic rc, wc, go_w, go_r;
   assign rc   = rd_crit_in | rd_go_crit;
   assign wc   = wr_crit_in | wr_go_crit;
   assign go_w = (wc && !rc) || (wr_pending && !rd_pending);
   assign go_r = (rc && !wc) || (rd_pending && !wr_pending);

   a_r1_reset_read: assert property (@(posedge clk) !rst_n |=> !mode_wr);

   a_r2_rd_to_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_wr && go_w) |=> mode_wr);

   a_r3_wr_to_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && go_r) |=> !mode_wr);

   a_r4_hold_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_wr && !go_w) |=> !mode_wr);

   a_r4_hold_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && !go_r) |=> mode_wr);

   a_r5_rd_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (urgent_fwd_en && (|rd_urgent)) |-> rd_go_crit);

   a_r5_wr_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (urgent_fwd_en && (|wr_urgent)) |-> wr_go_crit);

   a_r6_fwd_off: assert property (@(posedge clk) disable iff (!rst_n)
      !urgent_fwd_en |-> (!rd_go_crit && !wr_go_crit));
endmodule

bind rw_mode_arbiter rw_mode_arbiter_chk #(
   .RD_PORTS(RD_PORTS),
   .WR_PORTS(WR_PORTS)
) u_chk (.*);

// File: tb/rw_mode_arbiter_tb.sv
module rw_mode_arbiter_tb;
   localparam int RP = 2;
   localparam int WP = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_pending = 1'b0, wr_pending = 1'b0;
   logic          rd_crit_in = 1'b0, wr_crit_in = 1'b0;
   logic [RP-1:0] rd_urgent = '0;
   logic [WP-1:0] wr_urgent = '0;
   logic          urgent_fwd_en = 1'b0;
   logic          mode_wr, rd_go_crit, wr_go_crit;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   rw_mode_arbiter #(.RD_PORTS(RP), .WR_PORTS(WP)) u_dut (.*);

   task automatic check(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic force_mode(input logic want);
      @(negedge clk);
      rd_crit_in = 0; wr_crit_in = 0; urgent_fwd_en = 0;
      rd_urgent = '0; wr_urgent = '0;
      rd_pending = !want; wr_pending = want;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", mode_wr, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after release stays read
      check("R1 after release", mode_wr, 1'b0);

      for (int start = 0; start < 2; start++) begin
         for (int v = 0; v < 512; v++) begin
            logic rp, wp, rc, wc, en, rgo, wgo, rce, wce, exp_m;
            logic [RP-1:0] ru;
            logic [WP-1:0] wu;
            force_mode(start[0]);
            check("R2/R3 setup", mode_wr, start[0]);
            rp = v[0]; wp = v[1]; rc = v[2]; wc = v[3]; en = v[4];
            ru = v[6:5]; wu = v[8:7];
            rd_pending = rp; wr_pending = wp; rd_crit_in = rc; wr_crit_in = wc;
            urgent_fwd_en = en; rd_urgent = ru; wr_urgent = wu;
            #1;
            rgo = en & (ru != 0);
            wgo = en & (wu != 0);
            check("R5/R6 rd_go_crit", rd_go_crit, rgo);
            check("R5/R6 wr_go_crit", wr_go_crit, wgo);
            check("R8 no change before edge", mode_wr, start[0]);
            // R7: effective critical merges forwarded urgency
            rce = rc | rgo;
            wce = wc | wgo;
            exp_m = start[0];
            if (!start[0]) begin
               if ((wce && !rce) || (wp && !rp)) exp_m = 1'b1;
            end else begin
               if ((rce && !wce) || (rp && !wp)) exp_m = 1'b0;
            end
            @(negedge clk);
            if (exp_m != start[0])
               check(start[0] ? "R3 switch to read" : "R2 switch to write", mode_wr, exp_m);
            else
               check("R4 hold (R6/R7 urgency)", mode_wr, exp_m);
         end
      end

      rst_n = 1'b0;
      #1;
      check("R1 async reset", mode_wr, 1'b0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule